// File: doc/BRIEF.md
# Secondary Interrupt Concentrator with Per-Line Bypass

This block gathers 32 level-sensitive interrupt sources for a primary interrupt controller. Every clock it captures the source levels into a raw-status register. It masks them with a software-controlled enable register and ORs the result into a single registered request line. That line occupies one dedicated parent output. A configurable window of sources can also bypass the OR stage: each enabled source in the window drives its own parent output directly. The primary controller can then see and prioritise those sources individually.

Software reaches the block through a single-cycle register strobe. The word index is taken from the address bits above the byte offset. The enable mask has no plain write; it changes only through separate set and clear words, so one source can be changed without a read-modify-write. One further set/clear pair acts only on enable bit 0. The bypass-enable register has its own set/clear pair, and its set word accepts only bits inside the window.

Top module: `sec_irq_ctrl`

## Requirements
- R1: On each rising clock edge out of reset, the raw-status register takes the current value of `irq_in`, one bit per source. A high line gives 1 and a low line gives 0.
- R2: `parent_irq[31]` is the combined request. It is high in the cycle after any bit of (raw status AND enable mask) is set, and low in the cycle after that AND becomes zero.
- R3: The word index is `bus_addr[11:2]`, and `bus_addr[1:0]` is ignored. A read (`bus_valid`=1, `bus_write`=0) returns data in the same cycle. Index 0 gives raw AND mask, index 1 gives the raw status, and index 2 gives the enable mask. Index 4 gives raw bit 0 in bit 0 with zeros above it. Index 8 gives the bypass-enable register.
- R4: A write to index 2 ORs the write data into the enable mask. A write to index 3 clears every mask bit that is 1 in the data.
- R5: A write of any nonzero value to index 4 sets mask bit 0, and a nonzero write to index 5 clears it. A zero written to either index leaves the mask unchanged.
- R6: A write to index 8 ORs (data AND 0x7FE00000) into the bypass-enable register, so only bits 21 to 30 can ever be set. A write to index 9 clears every bypass bit that is 1 in the data.
- R7: For each bit i from 21 to 30 whose bypass enable is set, `parent_irq[i]` equals raw-status bit i. This holds in the cycle the raw bit changes and in the first cycle after the enable is set.
- R8: For each bit i from 21 to 30 whose bypass enable is clear, `parent_irq[i]` keeps the value it last had.
- R9: `parent_irq[20:0]` is always low, whatever the sources and registers hold.
- R10: A read of any index other than 0, 1, 2, 4 or 8 returns zero. A write to any index other than 2, 3, 4, 5, 8 or 9 changes no register.
- R11: While `rst_n` is low, the raw status, enable mask and bypass enables are zero and every `parent_irq` line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| parent_irq | output | 32 | Lines to the primary controller; bit 31 is the combined request |

## Verification
A walking single-one pattern on the sources is run three ways: with the mask clear, with a mixed mask, and with all bypass enables on. Each run reads every register word in every cycle. Together these tell apart a wrong bit in the raw capture, a mask applied to the wrong bit, and a combined line that is one cycle early or late. All-ones and all-zeros sources show that `parent_irq[20:0]` stays low and that an input outside the bypass window never reaches its own line. A partial bypass clear with the sources dropping separates a held line from one that follows or falls to zero. A later bypass set on a held-high line whose source is low shows that the line follows at once. Zero and nonzero writes to the bit-0 words, and writes to unused indices, are each followed by reads of all words.

// File: rtl/sec_irq_pkg.sv
`timescale 1ns/1ps
package sec_irq_pkg;

   // Word indices (address bits above the byte offset)
   localparam int unsigned IX_STATUS    = 0;
   localparam int unsigned IX_RAW       = 1;
   localparam int unsigned IX_EN_SET    = 2;
   localparam int unsigned IX_EN_CLR    = 3;
   localparam int unsigned IX_SOFT_SET  = 4;
   localparam int unsigned IX_SOFT_CLR  = 5;
   localparam int unsigned IX_ROUTE_SET = 8;
   localparam int unsigned IX_ROUTE_CLR = 9;

   // Role of one parent output line
   typedef enum logic [1:0] {
      LINE_TIED     = 2'd0,
      LINE_ROUTED   = 2'd1,
      LINE_COMBINED = 2'd2
   } line_kind_e;

   function automatic logic [63:0] span_mask(input int unsigned lo, input int unsigned hi);
      logic [63:0] m;
      m = '0;
      for (int unsigned b = 0; b < 64; b++) begin
         if (b >= lo && b <= hi) m[b] = 1'b1;
      end
      return m;
   endfunction

   function automatic line_kind_e classify(input int unsigned bitpos, input int unsigned lo,
                                           input int unsigned hi, input int unsigned comb);
      if (bitpos == comb) return LINE_COMBINED;
      if (bitpos >= lo && bitpos <= hi) return LINE_ROUTED;
      return LINE_TIED;
   endfunction

endpackage

// File: rtl/sec_irq_level.sv
`timescale 1ns/1ps
module sec_irq_level #(
   parameter int unsigned N_SRC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src,
   output logic [N_SRC-1:0] raw_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= src;
   end

endmodule

// File: rtl/sec_irq_regs.sv
`timescale 1ns/1ps
module sec_irq_regs
   import sec_irq_pkg::*;
#(
   parameter int unsigned N_SRC    = 32,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned ROUTE_LO = 21,
   parameter int unsigned ROUTE_HI = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [N_SRC-1:0]  bus_wdata,
   input  logic [N_SRC-1:0]  raw_q,
   output logic [N_SRC-1:0]  en_q,
   output logic [N_SRC-1:0]  route_q,
   output logic [N_SRC-1:0]  bus_rdata
);

   localparam int unsigned      IW  = ADDR_W - 2;
   localparam logic [N_SRC-1:0] WIN = N_SRC'(span_mask(ROUTE_LO, ROUTE_HI));

   logic [IW-1:0] idx;
   logic          wr_stb;
   logic          rd_stb;
   logic [1:0]    unused_byte;

   assign idx         = bus_addr[ADDR_W-1:2];
   assign unused_byte = bus_addr[1:0];
   assign wr_stb      = bus_valid & bus_write;
   assign rd_stb      = bus_valid & ~bus_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         route_q <= '0;
      end else if (wr_stb) begin
         case (idx)
            IW'(IX_EN_SET):    en_q    <= en_q | bus_wdata;
            IW'(IX_EN_CLR):    en_q    <= en_q & ~bus_wdata;
            IW'(IX_SOFT_SET):  if (|bus_wdata) en_q[0] <= 1'b1;
            IW'(IX_SOFT_CLR):  if (|bus_wdata) en_q[0] <= 1'b0;
            IW'(IX_ROUTE_SET): route_q <= route_q | (bus_wdata & WIN);
            IW'(IX_ROUTE_CLR): route_q <= route_q & ~bus_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_stb) begin
         case (idx)
            IW'(IX_STATUS):    bus_rdata = raw_q & en_q;
            IW'(IX_RAW):       bus_rdata = raw_q;
            IW'(IX_EN_SET):    bus_rdata = en_q;
            IW'(IX_SOFT_SET):  bus_rdata = {{(N_SRC-1){1'b0}}, raw_q[0]};
            IW'(IX_ROUTE_SET): bus_rdata = route_q;
            default:           bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/sec_irq_route.sv
`timescale 1ns/1ps
module sec_irq_route
   import sec_irq_pkg::*;
#(
   parameter int unsigned N_SRC     = 32,
   parameter int unsigned ROUTE_LO  = 21,
   parameter int unsigned ROUTE_HI  = 30,
   parameter int unsigned COMB_LINE = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] raw_q,
   input  logic [N_SRC-1:0] en_q,
   input  logic [N_SRC-1:0] route_q,
   output logic [N_SRC-1:0] parent_irq
);

   localparam logic [N_SRC-1:0] WIN = N_SRC'(span_mask(ROUTE_LO, ROUTE_HI));

   logic unused_route;
   assign unused_route = ^(route_q & ~WIN);

   for (genvar g = 0; g < N_SRC; g++) begin : g_line
      localparam line_kind_e KIND = classify(g, ROUTE_LO, ROUTE_HI, COMB_LINE);
      if (KIND == LINE_COMBINED) begin : g_comb
         logic comb_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) comb_q <= 1'b0;
            else        comb_q <= |(raw_q & en_q);
         end
         assign parent_irq[g] = comb_q;
      end else if (KIND == LINE_ROUTED) begin : g_route
         logic hold_q;
         logic line;
         assign line = route_q[g] ? raw_q[g] : hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hold_q <= 1'b0;
            else        hold_q <= line;
         end
         assign parent_irq[g] = line;
      end else begin : g_tied
         assign parent_irq[g] = 1'b0;
      end
   end

endmodule

// File: rtl/sec_irq_ctrl.sv
`timescale 1ns/1ps
module sec_irq_ctrl #(
   parameter int unsigned N_SRC     = 32,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned ROUTE_LO  = 21,
   parameter int unsigned ROUTE_HI  = 30,
   parameter int unsigned COMB_LINE = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [N_SRC-1:0]  bus_wdata,
   output logic [N_SRC-1:0]  bus_rdata,
   output logic [N_SRC-1:0]  parent_irq
);

   if (N_SRC < 2 || N_SRC > 64) begin : g_bad_width
      $error("sec_irq_ctrl: N_SRC must be 2..64");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("sec_irq_ctrl: ADDR_W too small for word index 9");
   end
   if (ROUTE_LO > ROUTE_HI || ROUTE_HI >= N_SRC) begin : g_bad_window
      $error("sec_irq_ctrl: bypass window out of range");
   end
   if (COMB_LINE >= N_SRC || (COMB_LINE >= ROUTE_LO && COMB_LINE <= ROUTE_HI)) begin : g_bad_comb
      $error("sec_irq_ctrl: combined line overlaps window or exceeds width");
   end

   logic [N_SRC-1:0] raw_q;
   logic [N_SRC-1:0] en_q;
   logic [N_SRC-1:0] route_q;

   sec_irq_level #(.N_SRC(N_SRC)) u_level (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (irq_in),
      .raw_q (raw_q)
   );

   sec_irq_regs #(
      .N_SRC(N_SRC), .ADDR_W(ADDR_W), .ROUTE_LO(ROUTE_LO), .ROUTE_HI(ROUTE_HI)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .raw_q     (raw_q),
      .en_q      (en_q),
      .route_q   (route_q),
      .bus_rdata (bus_rdata)
   );

   sec_irq_route #(
      .N_SRC(N_SRC), .ROUTE_LO(ROUTE_LO), .ROUTE_HI(ROUTE_HI), .COMB_LINE(COMB_LINE)
   ) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw_q      (raw_q),
      .en_q       (en_q),
      .route_q    (route_q),
      .parent_irq (parent_irq)
   );

endmodule

// File: rtl/sec_irq_chk.sv
`timescale 1ns/1ps
module sec_irq_chk
   import sec_irq_pkg::*;
#(
   parameter int unsigned N_SRC     = 32,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned ROUTE_LO  = 21,
   parameter int unsigned ROUTE_HI  = 30,
   parameter int unsigned COMB_LINE = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_SRC-1:0]  irq_in,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [N_SRC-1:0]  bus_wdata,
   input logic [N_SRC-1:0]  bus_rdata,
   input logic [N_SRC-1:0]  parent_irq,
   input logic [N_SRC-1:0]  raw_q,
   input logic [N_SRC-1:0]  en_q,
   input logic [N_SRC-1:0]  route_q
);

   localparam int unsigned      IW  = ADDR_W - 2;
   localparam logic [N_SRC-1:0] WIN = N_SRC'(span_mask(ROUTE_LO, ROUTE_HI));

   logic [IW-1:0] idx;
   logic          rd_undef;
   assign idx = bus_addr[ADDR_W-1:2];
   assign rd_undef = bus_valid && !bus_write &&
                     idx != IW'(IX_STATUS) && idx != IW'(IX_RAW) && idx != IW'(IX_EN_SET) &&
                     idx != IW'(IX_SOFT_SET) && idx != IW'(IX_ROUTE_SET);

   a_r1_raw_capture: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> raw_q == $past(irq_in));

   a_r2_comb_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (|(raw_q & en_q)) |=> parent_irq[COMB_LINE]);

   a_r2_comb_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(raw_q & en_q)) |=> !parent_irq[COMB_LINE]);

   a_r4_en_set: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && idx == IW'(IX_EN_SET)) |=>
         (en_q & $past(bus_wdata)) == $past(bus_wdata));

   a_r6_route_window: assert property (@(posedge clk) disable iff (!rst_n)
      (route_q & ~WIN) == '0);

   a_r9_low_lines: assert property (@(posedge clk) disable iff (!rst_n)
      parent_irq[ROUTE_LO-1:0] == '0);

   a_r10_undef_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_undef |-> bus_rdata == '0);

   for (genvar g = ROUTE_LO; g <= ROUTE_HI; g++) begin : g_bit
      a_r7_follow: assert property (@(posedge clk) disable iff (!rst_n)
         route_q[g] |-> parent_irq[g] == raw_q[g]);
      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !route_q[g] |-> parent_irq[g] == $past(parent_irq[g]));
   end

endmodule

bind sec_irq_ctrl sec_irq_chk #(
   .N_SRC(N_SRC), .ADDR_W(ADDR_W), .ROUTE_LO(ROUTE_LO), .ROUTE_HI(ROUTE_HI), .COMB_LINE(COMB_LINE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_in     (irq_in),
   .bus_valid  (bus_valid),
   .bus_write  (bus_write),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .parent_irq (parent_irq),
   .raw_q      (raw_q),
   .en_q       (en_q),
   .route_q    (route_q)
);

// File: tb/sec_irq_ctrl_test.sv
`timescale 1ns/1ps
module sec_irq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] parent_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sec_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .parent_irq(parent_irq)
   );

   // Cycle model built from the requirements
   logic [31:0] m_raw, m_en, m_pt, m_line, m_d;
   logic        m_comb;
   int          m_ix;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_raw = '0; m_en = '0; m_pt = '0; m_line = '0; m_comb = 1'b0;
      end else begin
         m_comb = |(m_raw & m_en);
         m_raw  = irq_in;
         if (bus_valid && bus_write) begin
            m_ix = int'(bus_addr[11:2]);
            m_d  = bus_wdata;
            case (m_ix)
               2: m_en = m_en | m_d;
               3: m_en = m_en & ~m_d;
               4: if (m_d != 0) m_en[0] = 1'b1;
               5: if (m_d != 0) m_en[0] = 1'b0;
               8: m_pt = m_pt | (m_d & 32'h7FE0_0000);
               9: m_pt = m_pt & ~m_d;
               default: ;
            endcase
         end
         for (int i = 21; i <= 30; i++) if (m_pt[i]) m_line[i] = m_raw[i];
      end
   end

   function automatic logic [31:0] exp_parent();
      return {m_comb, m_line[30:21], 21'b0};
   endfunction

   function automatic logic [31:0] exp_rd(int ix);
      case (ix)
         0: return m_raw & m_en;
         1: return m_raw;
         2: return m_en;
         4: return {31'b0, m_raw[0]};
         8: return m_pt;
         default: return 32'h0;
      endcase
   endfunction

   task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic cycle();
      @(negedge clk);
   endtask

   // Called just after a falling edge: parent lines plus a read of every word
   task automatic check_all(string req);
      int ixs[12] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 1023};
      check32(req, "parent_irq", parent_irq, exp_parent());
      for (int k = 0; k < 12; k++) begin
         bus_addr  = 12'(ixs[k] * 4 + 3);
         bus_valid = 1'b1;
         bus_write = 1'b0;
         #0.1;
         check32(req, $sformatf("read word %0d", ixs[k]), bus_rdata, exp_rd(ixs[k]));
         bus_valid = 1'b0;
      end
   endtask

   task automatic wr(int ix, logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'(ix * 4 + 1); bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R11: reset clears everything even with all sources high
      irq_in = 32'hFFFF_FFFF;
      repeat (3) cycle();
      check_all("R11");
      rst_n = 1'b1;
      irq_in = '0;
      cycle(); cycle();
      check_all("R11");

      // R1 R3: walking one, mask clear
      for (int i = 0; i < 32; i++) begin
         irq_in = 32'h1 << i;
         cycle();
         check_all("R1");
      end

      // R4: set / clear of enable mask
      wr(2, 32'hA5A5_00FF); check_all("R4");
      wr(3, 32'h0000_00F0); check_all("R4");

      // R2: walking one with mixed mask, each step checked over two cycles
      for (int i = 0; i < 32; i++) begin
         irq_in = 32'h1 << i;
         cycle(); check_all("R2");
         cycle(); check_all("R2");
      end
      irq_in = 32'hFFFF_FFFF; cycle(); cycle(); check_all("R2");
      irq_in = 32'h0;         cycle(); check_all("R2"); cycle(); check_all("R2");

      // R5: bit-0 words, zero writes ignored
      irq_in = 32'h1;
      wr(5, 32'h0);          check_all("R5");
      wr(5, 32'h8000_0000);  check_all("R5");
      cycle();               check_all("R5");
      wr(4, 32'h0);          check_all("R5");
      wr(4, 32'h2);          check_all("R5");
      cycle();               check_all("R5");

      // R10: writes to unused indices
      wr(6, 32'hFFFF_FFFF);  check_all("R10");
      wr(7, 32'hFFFF_FFFF);  check_all("R10");
      wr(12, 32'hFFFF_FFFF); check_all("R10");
      wr(1023, 32'hFFFF_FFFF); check_all("R10");

      // R6: bypass set limited to window
      wr(8, 32'hFFFF_FFFF);  check_all("R6");

      // R7: walking one across all sources with bypass on
      for (int i = 0; i < 32; i++) begin
         irq_in = 32'h1 << i;
         cycle(); check_all("R7");
      end

      // R9: low sources never reach their own lines
      irq_in = 32'h001F_FFFF; cycle(); check_all("R9");
      irq_in = 32'hFFFF_FFFF; cycle(); check_all("R9");

      // R8: partial bypass clear, sources drop, cleared lines hold high
      irq_in = 32'h7FE0_0000; cycle(); check_all("R8");
      wr(9, 32'h5540_0000);   check_all("R8");
      irq_in = 32'h0; cycle(); check_all("R8");
      cycle();                check_all("R8");
      check32("R8", "held line 24", {31'b0, parent_irq[24]}, 32'h1);

      // R7: re-enabling a held line makes it follow at once
      wr(8, 32'h0100_0000);   check_all("R7");
      check32("R7", "line 24 follows", {31'b0, parent_irq[24]}, 32'h0);
      wr(9, 32'hFFFF_FFFF);   check_all("R6");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule